// File: doc/BRIEF.md
# Cipher Job Sequencer for Paired Block Buffers

This block sits between a register bus and an external block-cipher core. It runs jobs over two on-chip buffers, one holding plaintext and one holding ciphertext. Software programs a start block in each buffer, a block count and an initialization vector. It then writes a control word with the start bit set. The controller steps through the blocks one at a time. For each block it presents a source block address, a destination block address, the mode and the IV to the cipher core over a request/acknowledge handshake.

An external monitor can forbid work. While its blocked input is high, start commands have no effect. Before a job is launched, the controller checks that both buffer ranges fit. It also handles a buffer-wipe handshake, reports sticky error flags and raises an interrupt when a job or a wipe finishes.

Top module: `cipher_job_ctrl`

## Requirements
- R1: Registers sit at word addresses 0 control, 1 block count minus one, 2 plaintext start block, 3 ciphertext start block, 4 status (read-only), 5 error flags, 6 interrupt control, 7 configuration (read-only), 8 and 9 IV low and high word. Configuration reads bytes-per-block in bits 6:0, the plaintext buffer size in blocks in bits 16:7 and the ciphertext buffer size in blocks in bits 26:17. Reset status reads 0x800.
- R2: Writing the control word with bit 2 set, while idle, unblocked and in range, starts a job of (count register + 1) blocks. Blocks are requested in order. `core_first` is high only on the first block, and each block is held until `core_ack`.
- R3: With control bit 0 clear (encrypt), block i reads plaintext block pt_start+i and writes ciphertext block ct_start+i, with `core_src_sel`=0. With bit 0 set (decrypt), block i reads ciphertext block ct_start+i and writes plaintext block pt_start+i, with `core_src_sel`=1.
- R4: `core_cbc` follows control bit 1 (chaining when set, independent blocks when clear). `core_decrypt` follows bit 0. `core_iv` is {IV high word, IV low word}.
- R5: Status bit 0 (busy) and bit 2 (ciphering) are set from the launch until the last block is acknowledged. In the cycle busy drops, bit 10 (cipher done) and bit 8 (interrupt pending) become set.
- R6: A start whose plaintext range or ciphertext range runs past that buffer's size does not run. Instead it sets status bit 12 and error bit 0. A range that ends exactly at the last block runs.
- R7: While `monitor_blocked` is high, a start command is ignored. Status bit 3 equals `monitor_blocked` and status bit 11 is its inverse.
- R8: `irq` is interrupt-pending and not masked. Interrupt-control bit 0 is the mask. Writing interrupt-control bit 1 clears interrupt pending, cipher done and wipe done.
- R9: Writing interrupt-control bit 2 while idle raises `wipe_req` and sets status bits 0 and 1 until `wipe_ack`. Then wipe done (bit 9) and interrupt pending are set. If `wipe_fail` is high at the acknowledge, status bit 4 and error bit 1 are also set.
- R10: The error register reads bit 0 length error, bit 1 wipe failure and bit 2 internal error. Writing zero clears all three, and writing any non-zero value leaves them unchanged.
- R11: A `core_ack` that arrives while no block is requested sets the internal-error flag (status bit 6, error bit 2).
- R12: While busy, writes to the control, count, start and IV registers are ignored.
- R13: Status bit 7 reflects the `key_secret` input. Status bit 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| monitor_blocked | input | 1 | Monitor forbids cipher work |
| key_secret | input | 1 | Cipher core uses the secret key |
| core_req | output | 1 | Block request to cipher core |
| core_ack | input | 1 | Block accepted/finished by core |
| core_src_sel | output | 1 | Source buffer: 0 plaintext, 1 ciphertext |
| core_src_blk | output | 10 | Source block address |
| core_dst_blk | output | 10 | Destination block address |
| core_first | output | 1 | First block of the job |
| core_decrypt | output | 1 | Decrypt direction |
| core_cbc | output | 1 | Chained mode |
| core_iv | output | 64 | Initialization vector |
| wipe_req | output | 1 | Buffer wipe request |
| wipe_ack | input | 1 | Wipe finished |
| wipe_fail | input | 1 | Wipe failed, valid with wipe_ack |
| irq | output | 1 | Interrupt |

## Verification
The sequencer is driven with four job shapes:
- a single-block encryption;
- a multi-block chained encryption;
- a chained decryption with a late register write;
- an encryption that ends exactly on the last buffer block.

The single block separates the count-minus-one encoding from an off-by-one. The decryption catches a swapped buffer direction. The exact fit tells `<` from `<=` in the range check.

Further starts are made that overrun either the source buffer or the destination buffer, and others that arrive while the monitor is blocking. Each of these must produce no block request at all. Stray acknowledges and wipe handshakes, with and without failure, exercise the sticky flags and the zero-write clear.

// File: rtl/cjc_pkg.sv
// Shared constants and types for the cipher job controller.
// Assumes a word-addressed register bus with 4 address bits and 32-bit data.
package cjc_pkg;

    localparam int FIELD_W = 10;   // width of block-count and block-address fields
    localparam int WORD_W  = 32;

    localparam logic [3:0] ADDR_CTRL     = 4'd0;
    localparam logic [3:0] ADDR_LEN      = 4'd1;
    localparam logic [3:0] ADDR_PT_START = 4'd2;
    localparam logic [3:0] ADDR_CT_START = 4'd3;
    localparam logic [3:0] ADDR_STATUS   = 4'd4;
    localparam logic [3:0] ADDR_ERR      = 4'd5;
    localparam logic [3:0] ADDR_IRQ      = 4'd6;
    localparam logic [3:0] ADDR_CFG      = 4'd7;
    localparam logic [3:0] ADDR_IV0      = 4'd8;

    localparam int ST_BUSY      = 0;
    localparam int ST_WIPING    = 1;
    localparam int ST_CIPHERING = 2;
    localparam int ST_BLOCKED   = 3;
    localparam int ST_WIPE_FAIL = 4;
    localparam int ST_BAD_KEY   = 5;
    localparam int ST_INT_ERR   = 6;
    localparam int ST_KEY_SEC   = 7;
    localparam int ST_IRQ_PEND  = 8;
    localparam int ST_WIPE_DONE = 9;
    localparam int ST_CIPH_DONE = 10;
    localparam int ST_UNBLOCKED = 11;
    localparam int ST_LEN_ERR   = 12;

    typedef struct packed {
        logic               decrypt;
        logic               cbc;
        logic [FIELD_W-1:0] len;
        logic [FIELD_W-1:0] pt_start;
        logic [FIELD_W-1:0] ct_start;
    } job_cfg_t;

    typedef struct packed {
        logic busy;
        logic wiping;
        logic ciphering;
        logic wipe_fail;
        logic int_err;
        logic irq_pend;
        logic wipe_done;
        logic ciph_done;
        logic len_err;
    } seq_flags_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_WIPE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cjc_range.sv
// Range checker: tells whether a run of (count_m1 + 1) blocks starting at
// `start` stays inside a buffer of `limit` blocks.
// Assumes all fields are FIELD_W wide; the sum is formed one bit wider.
module cjc_range #(
    parameter int FIELD_W = 10
) (
    input  logic [FIELD_W-1:0] start,
    input  logic [FIELD_W-1:0] count_m1,
    input  logic [FIELD_W-1:0] limit,
    output logic               fits
);
    localparam int SUM_W = FIELD_W + 1;

    logic [SUM_W-1:0] end_excl;

    // One past the last block touched, compared against the buffer size.
    always_comb begin
        end_excl = {1'b0, start} + {1'b0, count_m1} + SUM_W'(1);
        fits     = end_excl <= {1'b0, limit};
    end
endmodule

// File: rtl/cjc_regs.sv
// Register file of the cipher job controller: holds the job setup, the IV
// words and the interrupt mask, decodes command bits into pulses and muxes
// read data. Assumes one bus access per cycle; job registers are locked
// while the sequencer is busy or a start is pending.
module cjc_regs
    import cjc_pkg::*;
#(
    parameter int BLOCK_BYTES = 8,
    parameter int PT_BLOCKS   = 64,
    parameter int CT_BLOCKS   = 64,
    parameter int IV_WORDS    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [3:0]                 bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic                       monitor_blocked,
    input  logic                       key_secret,
    input  seq_flags_t                 flags,
    output job_cfg_t                   cfg,
    output logic [IV_WORDS*WORD_W-1:0] iv,
    output logic                       irq_mask,
    output logic                       start_cmd,
    output logic                       clr_irq,
    output logic                       wipe_cmd,
    output logic                       err_clr
);
    localparam logic [WORD_W-1:0] CFG_WORD =
        (WORD_W'(BLOCK_BYTES) & 32'h7F)
        | (WORD_W'(PT_BLOCKS) << 7)
        | (WORD_W'(CT_BLOCKS) << 17);

    logic              hold;
    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] err_w;

    assign hold = flags.busy | start_cmd;

    // Command pulses that act in the same cycle as the write.
    assign clr_irq  = bus_wr && (bus_addr == ADDR_IRQ) && bus_wdata[1];
    assign wipe_cmd = bus_wr && (bus_addr == ADDR_IRQ) && bus_wdata[2];
    assign err_clr  = bus_wr && (bus_addr == ADDR_ERR) && (bus_wdata == '0);

    // Job setup registers, mask and the registered start command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= '0;
            irq_mask  <= 1'b0;
            start_cmd <= 1'b0;
        end else begin
            start_cmd <= bus_wr && (bus_addr == ADDR_CTRL) && bus_wdata[2] && !hold;
            if (bus_wr && !hold) begin
                case (bus_addr)
                    ADDR_CTRL: begin
                        cfg.decrypt <= bus_wdata[0];
                        cfg.cbc     <= bus_wdata[1];
                    end
                    ADDR_LEN:      cfg.len      <= bus_wdata[FIELD_W-1:0];
                    ADDR_PT_START: cfg.pt_start <= bus_wdata[FIELD_W-1:0];
                    ADDR_CT_START: cfg.ct_start <= bus_wdata[FIELD_W-1:0];
                    default: ;
                endcase
            end
            if (bus_wr && (bus_addr == ADDR_IRQ)) begin
                irq_mask <= bus_wdata[0];
            end
        end
    end

    // One register per IV word, repeated by parameter.
    for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
        logic [WORD_W-1:0] word_q;

        // Capture this IV word when addressed and not locked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (bus_wr && !hold && (bus_addr == 4'(ADDR_IV0 + g))) begin
                word_q <= bus_wdata;
            end
        end

        assign iv[g*WORD_W +: WORD_W] = word_q;
    end

    // Assemble the status word from sequencer flags and monitor inputs.
    always_comb begin
        status_w               = '0;
        status_w[ST_BUSY]      = flags.busy;
        status_w[ST_WIPING]    = flags.wiping;
        status_w[ST_CIPHERING] = flags.ciphering;
        status_w[ST_BLOCKED]   = monitor_blocked;
        status_w[ST_WIPE_FAIL] = flags.wipe_fail;
        status_w[ST_BAD_KEY]   = 1'b0;
        status_w[ST_INT_ERR]   = flags.int_err;
        status_w[ST_KEY_SEC]   = key_secret;
        status_w[ST_IRQ_PEND]  = flags.irq_pend;
        status_w[ST_WIPE_DONE] = flags.wipe_done;
        status_w[ST_CIPH_DONE] = flags.ciph_done;
        status_w[ST_UNBLOCKED] = !monitor_blocked;
        status_w[ST_LEN_ERR]   = flags.len_err;
        err_w                  = {29'd0, flags.int_err, flags.wipe_fail, flags.len_err};
    end

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:     bus_rdata = {30'd0, cfg.cbc, cfg.decrypt};
            ADDR_LEN:      bus_rdata = WORD_W'(cfg.len);
            ADDR_PT_START: bus_rdata = WORD_W'(cfg.pt_start);
            ADDR_CT_START: bus_rdata = WORD_W'(cfg.ct_start);
            ADDR_STATUS:   bus_rdata = status_w;
            ADDR_ERR:      bus_rdata = err_w;
            ADDR_IRQ:      bus_rdata = {31'd0, irq_mask};
            ADDR_CFG:      bus_rdata = CFG_WORD;
            default: begin
                for (int k = 0; k < IV_WORDS; k++) begin
                    if (bus_addr == 4'(ADDR_IV0 + k)) begin
                        bus_rdata = iv[k*WORD_W +: WORD_W];
                    end
                end
            end
        endcase
    end

    // Job registers must not move while a job is running.
    assert_len_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_LEN) && flags.busy) |=> $stable(cfg.len));

    assert_start_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_PT_START) && flags.busy) |=> $stable(cfg.pt_start));

endmodule

// File: rtl/cjc_seq.sv
// Job sequencer: launches a job on a start command when the monitor allows
// it and both ranges fit, walks the blocks through a request/acknowledge
// handshake with the cipher core, runs the wipe handshake and keeps the
// done, interrupt and sticky error flags.
// Assumes the core holds core_ack for one cycle per block.
module cjc_seq
    import cjc_pkg::*;
#(
    parameter int PT_BLOCKS = 64,
    parameter int CT_BLOCKS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  job_cfg_t           cfg,
    input  logic               start_cmd,
    input  logic               fits_all,
    input  logic               monitor_blocked,
    input  logic               clr_irq,
    input  logic               wipe_cmd,
    input  logic               err_clr,
    input  logic               core_ack,
    input  logic               wipe_ack,
    input  logic               wipe_fail,
    output logic               core_req,
    output logic               core_src_sel,
    output logic [FIELD_W-1:0] core_src_blk,
    output logic [FIELD_W-1:0] core_dst_blk,
    output logic               core_first,
    output logic               core_decrypt,
    output logic               core_cbc,
    output logic               wipe_req,
    output seq_flags_t         flags
);
    seq_state_e         st_q;
    logic [FIELD_W-1:0] idx_q;
    logic [FIELD_W-1:0] len_q;
    logic [FIELD_W-1:0] src_q;
    logic [FIELD_W-1:0] dst_q;
    logic               dec_q;
    logic               cbc_q;

    logic idle, hs, last, done_ev, launch, reject, wipe_go, wipe_end, stray;

    // Event decode for the current cycle.
    always_comb begin
        idle     = (st_q == SQ_IDLE);
        hs       = (st_q == SQ_RUN) && core_ack;
        last     = (idx_q == len_q);
        done_ev  = hs && last;
        launch   = start_cmd && idle && !monitor_blocked && fits_all;
        reject   = start_cmd && idle && !monitor_blocked && !fits_all;
        wipe_go  = wipe_cmd && idle && !start_cmd;
        wipe_end = (st_q == SQ_WIPE) && wipe_ack;
        stray    = core_ack && (st_q != SQ_RUN);
    end

    // Main state machine and latched job parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            idx_q <= '0;
            len_q <= '0;
            src_q <= '0;
            dst_q <= '0;
            dec_q <= 1'b0;
            cbc_q <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (launch) begin
                        st_q  <= SQ_RUN;
                        idx_q <= '0;
                        len_q <= cfg.len;
                        dec_q <= cfg.decrypt;
                        cbc_q <= cfg.cbc;
                        src_q <= cfg.decrypt ? cfg.ct_start : cfg.pt_start;
                        dst_q <= cfg.decrypt ? cfg.pt_start : cfg.ct_start;
                    end else if (wipe_go) begin
                        st_q <= SQ_WIPE;
                    end
                end
                SQ_RUN: begin
                    if (hs) begin
                        if (last) begin
                            st_q <= SQ_IDLE;
                        end else begin
                            idx_q <= idx_q + FIELD_W'(1);
                        end
                    end
                end
                SQ_WIPE: begin
                    if (wipe_ack) begin
                        st_q <= SQ_IDLE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Completion flags: set on finish, cleared by the interrupt-clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.ciph_done <= 1'b0;
            flags.wipe_done <= 1'b0;
            flags.irq_pend  <= 1'b0;
        end else begin
            if (done_ev) begin
                flags.ciph_done <= 1'b1;
            end else if (clr_irq || launch) begin
                flags.ciph_done <= 1'b0;
            end
            if (wipe_end) begin
                flags.wipe_done <= 1'b1;
            end else if (clr_irq || wipe_go) begin
                flags.wipe_done <= 1'b0;
            end
            if (done_ev || wipe_end) begin
                flags.irq_pend <= 1'b1;
            end else if (clr_irq) begin
                flags.irq_pend <= 1'b0;
            end
        end
    end

    // Sticky error flags: set by their events, cleared by a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.len_err   <= 1'b0;
            flags.wipe_fail <= 1'b0;
            flags.int_err   <= 1'b0;
        end else begin
            if (reject) begin
                flags.len_err <= 1'b1;
            end else if (err_clr) begin
                flags.len_err <= 1'b0;
            end
            if (wipe_end && wipe_fail) begin
                flags.wipe_fail <= 1'b1;
            end else if (err_clr) begin
                flags.wipe_fail <= 1'b0;
            end
            if (stray) begin
                flags.int_err <= 1'b1;
            end else if (err_clr) begin
                flags.int_err <= 1'b0;
            end
        end
    end

    // State-derived flags and core-facing outputs.
    always_comb begin
        flags.busy      = (st_q != SQ_IDLE);
        flags.wiping    = (st_q == SQ_WIPE);
        flags.ciphering = (st_q == SQ_RUN);
        core_req        = (st_q == SQ_RUN);
        wipe_req        = (st_q == SQ_WIPE);
        core_src_sel    = dec_q;
        core_decrypt    = dec_q;
        core_cbc        = cbc_q;
        core_first      = (idx_q == '0);
        core_src_blk    = src_q + idx_q;
        core_dst_blk    = dst_q + idx_q;
    end

    assert_done_same_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_ack && last) |=> (!core_req && flags.ciph_done && flags.irq_pend));

    assert_next_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_ack && !last) |=> (core_req && !core_first));

    assert_launch_unblocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_req) |-> $past(!monitor_blocked));

    assert_src_in_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (int'(core_src_blk) < (core_src_sel ? CT_BLOCKS : PT_BLOCKS)));

    assert_dst_in_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (int'(core_dst_blk) < (core_src_sel ? PT_BLOCKS : CT_BLOCKS)));

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_irq && !done_ev && !wipe_end) |=> !flags.irq_pend);

    assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !core_ack && !wipe_ack && !reject)
        |=> (!flags.len_err && !flags.wipe_fail && !flags.int_err));

endmodule

// File: rtl/cipher_job_ctrl.sv
// Top of the cipher job controller: register file, two buffer range
// checkers (one per buffer, built by a generate loop) and the job
// sequencer. Buffer sizes must fit the 10-bit configuration fields.
module cipher_job_ctrl
    import cjc_pkg::*;
#(
    parameter int BLOCK_BYTES = 8,
    parameter int PT_BLOCKS   = 64,
    parameter int CT_BLOCKS   = 64,
    parameter int IV_WORDS    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [3:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic                       monitor_blocked,
    input  logic                       key_secret,
    output logic                       core_req,
    input  logic                       core_ack,
    output logic                       core_src_sel,
    output logic [9:0]                 core_src_blk,
    output logic [9:0]                 core_dst_blk,
    output logic                       core_first,
    output logic                       core_decrypt,
    output logic                       core_cbc,
    output logic [IV_WORDS*32-1:0]     core_iv,
    output logic                       wipe_req,
    input  logic                       wipe_ack,
    input  logic                       wipe_fail,
    output logic                       irq
);
    localparam int NUM_BUFS = 2;

    job_cfg_t      cfg;
    seq_flags_t    flags;
    logic          irq_mask;
    logic          start_cmd;
    logic          clr_irq;
    logic          wipe_cmd;
    logic          err_clr;
    logic [NUM_BUFS-1:0] fits_v;

    cjc_regs #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .PT_BLOCKS   (PT_BLOCKS),
        .CT_BLOCKS   (CT_BLOCKS),
        .IV_WORDS    (IV_WORDS)
    ) regs_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_wr          (bus_wr),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .monitor_blocked (monitor_blocked),
        .key_secret      (key_secret),
        .flags           (flags),
        .cfg             (cfg),
        .iv              (core_iv),
        .irq_mask        (irq_mask),
        .start_cmd       (start_cmd),
        .clr_irq         (clr_irq),
        .wipe_cmd        (wipe_cmd),
        .err_clr         (err_clr)
    );

    // One range checker per buffer; index 0 plaintext, 1 ciphertext.
    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_range
        cjc_range #(.FIELD_W(FIELD_W)) range_i (
            .start    ((b == 0) ? cfg.pt_start : cfg.ct_start),
            .count_m1 (cfg.len),
            .limit    ((b == 0) ? FIELD_W'(PT_BLOCKS) : FIELD_W'(CT_BLOCKS)),
            .fits     (fits_v[b])
        );
    end

    cjc_seq #(
        .PT_BLOCKS (PT_BLOCKS),
        .CT_BLOCKS (CT_BLOCKS)
    ) seq_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg             (cfg),
        .start_cmd       (start_cmd),
        .fits_all        (&fits_v),
        .monitor_blocked (monitor_blocked),
        .clr_irq         (clr_irq),
        .wipe_cmd        (wipe_cmd),
        .err_clr         (err_clr),
        .core_ack        (core_ack),
        .wipe_ack        (wipe_ack),
        .wipe_fail       (wipe_fail),
        .core_req        (core_req),
        .core_src_sel    (core_src_sel),
        .core_src_blk    (core_src_blk),
        .core_dst_blk    (core_dst_blk),
        .core_first      (core_first),
        .core_decrypt    (core_decrypt),
        .core_cbc        (core_cbc),
        .wipe_req        (wipe_req),
        .flags           (flags)
    );

    // Interrupt line: pending and not masked.
    assign irq = flags.irq_pend & ~irq_mask;

endmodule

// File: tb/cipher_job_ctrl_tb_top.sv
// Scoreboard bench: job tasks push expected block transfers into a queue,
// a cipher-core model pops and compares them at each acknowledge.
module cipher_job_ctrl_tb_top;

    typedef struct packed {
        logic       sel;
        logic [9:0] src;
        logic [9:0] dst;
        logic       first;
        logic       dec;
        logic       cbc;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        monitor_blocked = 1'b0;
    logic        key_secret = 1'b0;
    logic        core_req;
    logic        model_ack = 1'b0;
    logic        stray_ack = 1'b0;
    logic        core_ack;
    logic        core_src_sel;
    logic [9:0]  core_src_blk;
    logic [9:0]  core_dst_blk;
    logic        core_first;
    logic        core_decrypt;
    logic        core_cbc;
    logic [63:0] core_iv;
    logic        wipe_req;
    logic        wipe_ack = 1'b0;
    logic        wipe_fail = 1'b0;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    int    ack_gap = 2;
    xfer_t exp_q[$];
    logic [63:0] exp_iv = '0;
    logic [31:0] rv;

    localparam logic [3:0] A_CTRL = 4'd0, A_LEN = 4'd1, A_PT = 4'd2, A_CT = 4'd3,
                           A_STAT = 4'd4, A_ERR = 4'd5, A_IRQ = 4'd6, A_CFG = 4'd7,
                           A_IV0 = 4'd8, A_IV1 = 4'd9;

    assign core_ack = model_ack | stray_ack;

    always #4 clk = ~clk;

    cipher_job_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .monitor_blocked (monitor_blocked), .key_secret (key_secret),
        .core_req (core_req), .core_ack (core_ack), .core_src_sel (core_src_sel),
        .core_src_blk (core_src_blk), .core_dst_blk (core_dst_blk),
        .core_first (core_first), .core_decrypt (core_decrypt), .core_cbc (core_cbc),
        .core_iv (core_iv), .wipe_req (wipe_req), .wipe_ack (wipe_ack),
        .wipe_fail (wipe_fail), .irq (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver: push expected transfers, program the job, start it.
    task automatic launch(input logic dec, input logic cbc, input int pt, input int ct, input int nblk);
        for (int i = 0; i < nblk; i++) begin
            exp_q.push_back({dec, dec ? 10'(ct + i) : 10'(pt + i),
                             dec ? 10'(pt + i) : 10'(ct + i), (i == 0), dec, cbc});
        end
        wr(A_PT, 32'(pt));
        wr(A_CT, 32'(ct));
        wr(A_LEN, 32'(nblk - 1));
        wr(A_CTRL, {29'd0, 1'b1, cbc, dec});
        @(negedge clk);
        bus_addr = A_STAT;
        #1 chk("R5 busy+ciphering during job", 64'(bus_rdata[2:0] & 3'b101), 64'h5);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(A_STAT, s);
            if (!s[0]) break;
        end
        chk("R2 all expected blocks seen", 64'(exp_q.size()), 64'd0);
    endtask

    // Cipher-core model and scoreboard monitor.
    initial begin
        int cnt;
        xfer_t e;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (model_ack) begin
                model_ack = 1'b0;
                cnt = 0;
            end else if (core_req) begin
                if (cnt >= ack_gap) begin
                    if (exp_q.size() == 0) begin
                        checks++; errors++;
                        $display("FAIL R2: unexpected block request actual %h expected none",
                                 {core_src_sel, core_src_blk, core_dst_blk});
                    end else begin
                        e = exp_q.pop_front();
                        chk("R3 transfer fields", 64'({core_src_sel, core_src_blk, core_dst_blk,
                            core_first, core_decrypt, core_cbc}), 64'(e));
                        chk("R4 iv", core_iv, exp_iv);
                    end
                    model_ack = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state and configuration (R1, R13).
        rd(A_STAT, rv); chk("R1 reset status", 64'(rv), 64'h800);
        rd(A_CFG, rv);  chk("R1 config word", 64'(rv), 64'h802008);
        chk("R8 irq low after reset", 64'(irq), 64'd0);
        chk("R2 no request after reset", 64'(core_req), 64'd0);
        wr(A_PT, 32'h15);
        rd(A_PT, rv); chk("R1 start register readback", 64'(rv), 64'h15);
        wr(A_IV0, 32'h0123_4567);
        wr(A_IV1, 32'h89ab_cdef);
        exp_iv = 64'h89ab_cdef_0123_4567;

        // Single block, independent mode, encrypt (R2, R3, R5, R8).
        ack_gap = 3;
        launch(1'b0, 1'b0, 2, 5, 1);
        wait_idle();
        rd(A_STAT, rv); chk("R5 status after job", 64'(rv), 64'hD00);
        chk("R8 irq raised", 64'(irq), 64'd1);
        wr(A_IRQ, 32'h2);
        rd(A_STAT, rv); chk("R8 clear pending and done", 64'(rv), 64'h800);
        chk("R8 irq cleared", 64'(irq), 64'd0);

        // Chained encrypt, four blocks (R4).
        ack_gap = 1;
        launch(1'b0, 1'b1, 10, 20, 4);
        wait_idle();

        // Chained decrypt, three blocks, write to count while busy (R3, R12).
        ack_gap = 4;
        launch(1'b1, 1'b1, 30, 40, 3);
        wr(A_LEN, 32'd9);
        wr(A_IV0, 32'hdead_beef);
        wait_idle();
        rd(A_LEN, rv); chk("R12 count write ignored while busy", 64'(rv), 64'd2);
        rd(A_IV0, rv); chk("R12 iv write ignored while busy", 64'(rv), 64'h0123_4567);

        // Exact fit to the last plaintext block (R6).
        ack_gap = 0;
        launch(1'b0, 1'b0, 59, 0, 5);
        wait_idle();
        rd(A_STAT, rv); chk("R6 exact fit no length error", 64'(rv[12]), 64'd0);

        // Source overrun (R6, R10).
        wr(A_PT, 32'd60); wr(A_CT, 32'd0); wr(A_LEN, 32'd4); wr(A_CTRL, 32'h4);
        repeat (3) @(negedge clk);
        rd(A_STAT, rv);
        chk("R6 length error set", 64'(rv[12]), 64'd1);
        chk("R6 no job on overrun", 64'(rv[0]), 64'd0);
        rd(A_ERR, rv); chk("R10 error register length bit", 64'(rv), 64'd1);
        wr(A_ERR, 32'd7);
        rd(A_ERR, rv); chk("R10 nonzero write keeps flags", 64'(rv), 64'd1);
        wr(A_ERR, 32'd0);
        rd(A_ERR, rv); chk("R10 zero write clears", 64'(rv), 64'd0);

        // Destination overrun in encrypt direction (R6).
        wr(A_PT, 32'd0); wr(A_CT, 32'd62); wr(A_LEN, 32'd2); wr(A_CTRL, 32'h4);
        repeat (3) @(negedge clk);
        rd(A_STAT, rv); chk("R6 destination overrun error", 64'(rv[12]), 64'd1);
        wr(A_ERR, 32'd0);

        // Monitor blocking (R7).
        monitor_blocked = 1'b1;
        wr(A_CT, 32'd0); wr(A_LEN, 32'd0); wr(A_CTRL, 32'h4);
        repeat (3) @(negedge clk);
        rd(A_STAT, rv);
        chk("R7 blocked bits", 64'({rv[11], rv[3]}), 64'b01);
        chk("R7 start ignored", 64'({rv[12], rv[0]}), 64'd0);
        monitor_blocked = 1'b0;
        rd(A_STAT, rv); chk("R7 unblocked bits", 64'({rv[11], rv[3]}), 64'b10);

        // Masked interrupt (R8).
        wr(A_IRQ, 32'h2);
        wr(A_IRQ, 32'h1);
        ack_gap = 2;
        launch(1'b0, 1'b1, 0, 0, 2);
        wait_idle();
        chk("R8 masked irq stays low", 64'(irq), 64'd0);
        rd(A_STAT, rv); chk("R8 pending while masked", 64'(rv[8]), 64'd1);
        wr(A_IRQ, 32'h2);
        rd(A_STAT, rv); chk("R8 clear done flags", 64'(rv[10:8]), 64'd0);

        // Wipe handshake (R9).
        wr(A_IRQ, 32'h4);
        chk("R9 wipe request", 64'(wipe_req), 64'd1);
        rd(A_STAT, rv); chk("R9 wiping and busy", 64'(rv[1:0]), 64'd3);
        wipe_ack = 1'b1;
        @(negedge clk);
        wipe_ack = 1'b0;
        rd(A_STAT, rv); chk("R9 wipe done status", 64'(rv), 64'hB00);
        chk("R9 irq after wipe", 64'(irq), 64'd1);
        chk("R9 wipe request dropped", 64'(wipe_req), 64'd0);

        // Failing wipe (R9, R10).
        wr(A_IRQ, 32'h2);
        wr(A_IRQ, 32'h4);
        wipe_ack = 1'b1; wipe_fail = 1'b1;
        @(negedge clk);
        wipe_ack = 1'b0; wipe_fail = 1'b0;
        rd(A_STAT, rv); chk("R9 wipe fail status", 64'({rv[9], rv[4]}), 64'b11);
        rd(A_ERR, rv); chk("R10 wipe fail error bit", 64'(rv), 64'd2);
        wr(A_ERR, 32'd0);

        // Acknowledge with no request (R11).
        @(negedge clk);
        stray_ack = 1'b1;
        @(negedge clk);
        stray_ack = 1'b0;
        rd(A_ERR, rv); chk("R11 internal error bit", 64'(rv), 64'd4);
        rd(A_STAT, rv); chk("R11 internal error status", 64'(rv[6]), 64'd1);

        // Key status and bad-key bit (R13).
        key_secret = 1'b1;
        rd(A_STAT, rv); chk("R13 key and bad-key bits", 64'({rv[7], rv[5]}), 64'b10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule